// File: doc/BRIEF.md
# Flash Program and Erase Sequencer

This block sits on the host side of an asynchronous, byte-wide parallel flash bus. It turns one request into the whole bus dialogue. The request can be a byte program, a sector erase or a whole-chip erase. For each request the block writes the unlock and command bytes, then reads status back until the device reports the result. Every bus phase is counted in clock cycles: address set-up, write-enable low time, recovery after each strobe, and output-enable access time. The system clock therefore sets the bus timing, and no analog delay is needed.

Completion is found by one of two status methods, chosen per request. The first method compares status bit 7 against the expected value. The second method watches bit 6 for a change between two successive reads. In both methods status bit 5 gates the error path. A separate read watchdog bounds the total number of status reads. When a request fails, the block writes a return-to-read command before it reports done. The device then leaves its error state.

The data bus is split into an output, an output enable and an input, so the pad ring can build the tristate driver.

Top module: `flash_seq_top`

## Requirements
- R1: The program request (`req_kind` = 0) writes AAh to 555h, then 55h to 2AAh, then A0h to 555h, and then `req_data` to `req_addr`, in that order.
- R2: The sector-erase request (`req_kind` = 1) writes AAh@555h, 55h@2AAh, 80h@555h, AAh@555h, 55h@2AAh and then 30h@`req_addr`. The chip-erase request (`req_kind` = 2) uses the same first five writes and ends with 10h@555h.
- R3: Write-enable goes low only while chip-enable is low and output-enable is high. Each low pulse lasts exactly T_WP cycles. Address and write data do not change while write-enable is low.
- R4: Each status read is its own output-enable low pulse at `req_addr`. The block never drives the data bus while output-enable is low.
- R5: In bit-7 mode (`req_poll` = 0), a read whose bit 7 equals the expected value ends the request with pass. The expected value is bit 7 of `req_data` for a program and 1 for either erase.
- R6: In bit-7 mode, a mismatching read that has bit 5 set triggers exactly one more read. The request passes if bit 7 of that read matches and fails otherwise.
- R7: In toggle mode (`req_poll` = 1), bit 6 of two successive reads is compared. If it is equal, the request passes. If it differs and bit 5 of the later read is set, two more reads are made. The request fails if bit 6 differs between those two, and passes otherwise.
- R8: On failure the block writes F0h to address 0 before done. `pass` is 0 with done.
- R9: When MAX_POLL status reads have been made without a verdict, the request fails.
- R10: `done` is a one-cycle pulse with `busy` low. `busy` is high from the cycle after an accepted start until done. A start while busy, or with `req_kind` = 3, is ignored.
- R11: After reset the block is idle, with `busy`, `done` and `pass` low and all bus strobes high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_start | input | 1 | One-cycle request strobe |
| req_kind | input | 2 | 0 program, 1 sector erase, 2 chip erase, 3 none |
| req_poll | input | 1 | 0 bit-7 status, 1 toggle status |
| req_addr | input | AW | Target byte or sector address |
| req_data | input | 8 | Byte to program |
| busy | output | 1 | Request in progress |
| done | output | 1 | Request finished (one cycle) |
| pass | output | 1 | Result, valid with done |
| fl_addr | output | AW | Flash address |
| fl_dq_o | output | 8 | Flash write data |
| fl_dq_oe | output | 1 | Drive enable for flash data |
| fl_dq_i | input | 8 | Flash read data |
| fl_ce_n | output | 1 | Chip enable, active low |
| fl_oe_n | output | 1 | Output enable, active low |
| fl_we_n | output | 1 | Write enable, active low |

## Verification
The assertions check the bus rules on every cycle:
- write-enable is gated by chip-enable and output-enable;
- each write-enable pulse has the exact width, and address and data hold steady under it;
- the data bus is released while output-enable is low;
- the done pulse is one cycle wide and never overlaps busy;
- a recovery write has been seen before any failing done.

Other behaviour shows only in the bench scenarios. These are the command byte order for each request kind, and the status verdicts of both methods, including the last-moment recheck and the toggle confirmation. They also cover the watchdog expiry and the ignored starts. The bench replays each of these against a behavioural flash responder.

// File: rtl/flash_seq_pkg.sv
package flash_seq_pkg;

    typedef enum logic [1:0] {
        K_PROG   = 2'd0,
        K_SERASE = 2'd1,
        K_CERASE = 2'd2,
        K_NONE   = 2'd3
    } req_kind_e;

    typedef enum logic [1:0] {
        AS_555  = 2'd0,
        AS_2AA  = 2'd1,
        AS_TGT  = 2'd2,
        AS_ZERO = 2'd3
    } addr_sel_e;

    typedef enum logic [2:0] {
        PH_FIRST,
        PH_SCAN,
        PH_RECHECK,
        PH_CONF1,
        PH_CONF2
    } poll_ph_e;

    typedef enum logic [1:0] {
        V_MORE,
        V_PASS,
        V_FAIL
    } verdict_e;

    localparam logic [7:0] RESET_CMD = 8'hF0;

    // number of writes in a request's command sequence
    function automatic logic [2:0] seq_len(req_kind_e k);
        return (k == K_PROG) ? 3'd4 : 3'd6;
    endfunction

    function automatic logic [7:0] seq_byte(req_kind_e k, logic [2:0] i, logic [7:0] d);
        logic [7:0] b;
        case (i)
            3'd0, 3'd3: b = (k == K_PROG && i == 3'd3) ? d : 8'hAA;
            3'd1, 3'd4: b = 8'h55;
            3'd2:       b = (k == K_PROG) ? 8'hA0 : 8'h80;
            default:    b = (k == K_CERASE) ? 8'h10 : 8'h30;
        endcase
        return b;
    endfunction

    function automatic addr_sel_e seq_addr(req_kind_e k, logic [2:0] i);
        addr_sel_e a;
        case (i)
            3'd1, 3'd4: a = AS_2AA;
            3'd3:       a = (k == K_PROG) ? AS_TGT : AS_555;
            3'd5:       a = (k == K_SERASE) ? AS_TGT : AS_555;
            default:    a = AS_555;
        endcase
        return a;
    endfunction

endpackage

// File: rtl/flash_bus_cycle.sv
module flash_bus_cycle #(
    parameter int AW   = 18,
    parameter int T_AS = 2,
    parameter int T_WP = 4,
    parameter int T_WH = 2,
    parameter int T_OE = 3
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          go,
    input  logic          rd,
    input  logic [AW-1:0] addr,
    input  logic [7:0]    wdata,
    output logic          ack,
    output logic [7:0]    rdata,
    input  logic [7:0]    dq_i,
    output logic [AW-1:0] fl_addr,
    output logic [7:0]    dq_o,
    output logic          dq_oe,
    output logic          ce_n,
    output logic          oe_n,
    output logic          we_n
);
    localparam int TMAX = (T_AS > T_WP ? T_AS : T_WP) > (T_WH > T_OE ? T_WH : T_OE)
                        ? (T_AS > T_WP ? T_AS : T_WP) : (T_WH > T_OE ? T_WH : T_OE);
    localparam int CW = $clog2(TMAX + 1);

    typedef enum logic [1:0] {B_IDLE, B_SETUP, B_ACT, B_HOLD} bstate_e;

    bstate_e       st;
    logic [CW-1:0] cnt;
    logic          rd_q;
    logic [AW-1:0] addr_q;
    logic [7:0]    data_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            st     <= B_IDLE;
            cnt    <= '0;
            rd_q   <= 1'b0;
            addr_q <= '0;
            data_q <= '0;
            ack    <= 1'b0;
            rdata  <= '0;
        end else begin
            ack <= 1'b0;
            case (st)
                B_IDLE: if (go) begin
                    st     <= B_SETUP;
                    cnt    <= CW'(T_AS - 1);
                    rd_q   <= rd;
                    addr_q <= addr;
                    data_q <= wdata;
                end
                B_SETUP: if (cnt == '0) begin
                    st  <= B_ACT;
                    cnt <= rd_q ? CW'(T_OE - 1) : CW'(T_WP - 1);
                end else cnt <= cnt - 1'b1;
                B_ACT: if (cnt == '0) begin
                    if (rd_q) rdata <= dq_i;
                    st  <= B_HOLD;
                    cnt <= CW'(T_WH - 1);
                end else cnt <= cnt - 1'b1;
                default: if (cnt == '0) begin
                    st  <= B_IDLE;
                    ack <= 1'b1;
                end else cnt <= cnt - 1'b1;
            endcase
        end
    end

    assign fl_addr = addr_q;
    assign dq_o    = data_q;
    assign ce_n    = (st == B_IDLE);
    assign we_n    = !(st == B_ACT && !rd_q);
    assign oe_n    = !(st == B_ACT && rd_q);
    assign dq_oe   = (st != B_IDLE) && !rd_q;

endmodule

// File: rtl/flash_seq_ctrl.sv
module flash_seq_ctrl
    import flash_seq_pkg::*;
#(
    parameter int MAX_POLL = 1000
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       req_start,
    input  logic [1:0] req_kind,
    input  logic       req_poll,
    input  logic [7:0] req_data,
    output logic       busy,
    output logic       done,
    output logic       pass,
    output logic       bus_go,
    output logic       bus_rd,
    output addr_sel_e  bus_sel,
    output logic [7:0] bus_wdata,
    input  logic       bus_ack,
    input  logic [7:0] bus_rdata
);
    localparam int RCW = $clog2(MAX_POLL + 1);

    typedef enum logic [2:0] {
        C_IDLE, C_WR_GO, C_WR_WAIT, C_RD_GO, C_RD_WAIT, C_RST_GO, C_RST_WAIT, C_DONE
    } cstate_e;

    cstate_e        st;
    req_kind_e      kind_q;
    logic [7:0]     data_q;
    logic           poll_q;
    logic [2:0]     idx;
    poll_ph_e       ph;
    logic [7:0]     prev;
    logic [RCW-1:0] nreads;

    logic           exp7;
    verdict_e       vd;
    poll_ph_e       ph_nx;
    logic [RCW-1:0] nreads_nx;

    assign exp7      = (kind_q == K_PROG) ? data_q[7] : 1'b1;
    assign nreads_nx = nreads + 1'b1;

    // status-read verdict
    always_comb begin
        vd    = V_MORE;
        ph_nx = ph;
        if (!poll_q) begin
            if (ph == PH_RECHECK)             vd = (bus_rdata[7] == exp7) ? V_PASS : V_FAIL;
            else if (bus_rdata[7] == exp7)    vd = V_PASS;
            else if (bus_rdata[5])            ph_nx = PH_RECHECK;
        end else begin
            case (ph)
                PH_FIRST: ph_nx = PH_SCAN;
                PH_SCAN: begin
                    if (bus_rdata[6] == prev[6]) vd = V_PASS;
                    else if (bus_rdata[5])       ph_nx = PH_CONF1;
                end
                PH_CONF1: ph_nx = PH_CONF2;
                default:  vd = (bus_rdata[6] != prev[6]) ? V_FAIL : V_PASS;
            endcase
        end
        if (vd == V_MORE && nreads_nx >= RCW'(MAX_POLL)) vd = V_FAIL;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st     <= C_IDLE;
            kind_q <= K_PROG;
            data_q <= '0;
            poll_q <= 1'b0;
            idx    <= '0;
            ph     <= PH_FIRST;
            prev   <= '0;
            nreads <= '0;
            pass   <= 1'b0;
        end else begin
            case (st)
                C_IDLE: if (req_start && req_kind != K_NONE) begin
                    st     <= C_WR_GO;
                    kind_q <= req_kind_e'(req_kind);
                    data_q <= req_data;
                    poll_q <= req_poll;
                    idx    <= '0;
                    pass   <= 1'b0;
                end
                C_WR_GO: st <= C_WR_WAIT;
                C_WR_WAIT: if (bus_ack) begin
                    if (idx == seq_len(kind_q) - 3'd1) begin
                        st     <= C_RD_GO;
                        ph     <= poll_q ? PH_FIRST : PH_SCAN;
                        nreads <= '0;
                    end else begin
                        idx <= idx + 3'd1;
                        st  <= C_WR_GO;
                    end
                end
                C_RD_GO: st <= C_RD_WAIT;
                C_RD_WAIT: if (bus_ack) begin
                    nreads <= nreads_nx;
                    prev   <= bus_rdata;
                    ph     <= ph_nx;
                    case (vd)
                        V_PASS:  begin pass <= 1'b1; st <= C_DONE; end
                        V_FAIL:  st <= C_RST_GO;
                        default: st <= C_RD_GO;
                    endcase
                end
                C_RST_GO:   st <= C_RST_WAIT;
                C_RST_WAIT: if (bus_ack) st <= C_DONE;
                default:    st <= C_IDLE;
            endcase
        end
    end

    always_comb begin
        bus_go    = (st == C_WR_GO) || (st == C_RD_GO) || (st == C_RST_GO);
        bus_rd    = (st == C_RD_GO);
        bus_sel   = AS_TGT;
        bus_wdata = RESET_CMD;
        if (st == C_WR_GO) begin
            bus_sel   = seq_addr(kind_q, idx);
            bus_wdata = seq_byte(kind_q, idx, data_q);
        end else if (st == C_RST_GO) begin
            bus_sel = AS_ZERO;
        end
    end

    assign busy = (st != C_IDLE) && (st != C_DONE);
    assign done = (st == C_DONE);

endmodule

// File: rtl/flash_seq_top.sv
module flash_seq_top
    import flash_seq_pkg::*;
#(
    parameter int AW       = 18,
    parameter int T_AS     = 2,
    parameter int T_WP     = 4,
    parameter int T_WH     = 2,
    parameter int T_OE     = 3,
    parameter int MAX_POLL = 1000
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          req_start,
    input  logic [1:0]    req_kind,
    input  logic          req_poll,
    input  logic [AW-1:0] req_addr,
    input  logic [7:0]    req_data,
    output logic          busy,
    output logic          done,
    output logic          pass,
    output logic [AW-1:0] fl_addr,
    output logic [7:0]    fl_dq_o,
    output logic          fl_dq_oe,
    input  logic [7:0]    fl_dq_i,
    output logic          fl_ce_n,
    output logic          fl_oe_n,
    output logic          fl_we_n
);
    logic          go, rd, ack;
    addr_sel_e     sel;
    logic [7:0]    wdata, rdata;
    logic [AW-1:0] tgt_q, bus_addr;

    always_ff @(posedge clk) begin
        if (rst)                       tgt_q <= '0;
        else if (req_start && !busy)   tgt_q <= req_addr;
    end

    always_comb begin
        case (sel)
            AS_555:  bus_addr = AW'(12'h555);
            AS_2AA:  bus_addr = AW'(12'h2AA);
            AS_TGT:  bus_addr = tgt_q;
            default: bus_addr = '0;
        endcase
    end

    flash_seq_ctrl #(.MAX_POLL(MAX_POLL)) u_ctrl (
        .clk(clk), .rst(rst),
        .req_start(req_start), .req_kind(req_kind), .req_poll(req_poll), .req_data(req_data),
        .busy(busy), .done(done), .pass(pass),
        .bus_go(go), .bus_rd(rd), .bus_sel(sel), .bus_wdata(wdata),
        .bus_ack(ack), .bus_rdata(rdata)
    );

    flash_bus_cycle #(.AW(AW), .T_AS(T_AS), .T_WP(T_WP), .T_WH(T_WH), .T_OE(T_OE)) u_bus (
        .clk(clk), .rst(rst),
        .go(go), .rd(rd), .addr(bus_addr), .wdata(wdata),
        .ack(ack), .rdata(rdata), .dq_i(fl_dq_i),
        .fl_addr(fl_addr), .dq_o(fl_dq_o), .dq_oe(fl_dq_oe),
        .ce_n(fl_ce_n), .oe_n(fl_oe_n), .we_n(fl_we_n)
    );

endmodule

// File: rtl/flash_seq_chk.sv
module flash_seq_chk #(
    parameter int AW   = 18,
    parameter int T_WP = 4
) (
    input logic          clk,
    input logic          rst,
    input logic          req_start,
    input logic          busy,
    input logic          done,
    input logic          pass,
    input logic [AW-1:0] fl_addr,
    input logic [7:0]    fl_dq_o,
    input logic          fl_dq_oe,
    input logic          fl_ce_n,
    input logic          fl_oe_n,
    input logic          fl_we_n
);
    logic [15:0] low_run;
    logic        we_q;
    logic        rcv_seen;

    always_ff @(posedge clk) begin
        if (rst) begin
            low_run  <= '0;
            we_q     <= 1'b1;
            rcv_seen <= 1'b0;
        end else begin
            we_q    <= fl_we_n;
            low_run <= fl_we_n ? 16'd0 : low_run + 16'd1;
            if (req_start && !busy)                      rcv_seen <= 1'b0;
            else if (fl_we_n && !we_q && fl_dq_o == 8'hF0) rcv_seen <= 1'b1;
        end
    end

    assert_we_gated_R3: assert property (@(posedge clk) disable iff (rst)
        !fl_we_n |-> (!fl_ce_n && fl_oe_n));

    assert_we_width_R3: assert property (@(posedge clk) disable iff (rst)
        (fl_we_n && !we_q) |-> (low_run == 16'(T_WP)));

    assert_we_stable_R3: assert property (@(posedge clk) disable iff (rst)
        (!fl_we_n && !we_q) |-> ($stable(fl_addr) && $stable(fl_dq_o)));

    assert_bus_release_R4: assert property (@(posedge clk) disable iff (rst)
        !fl_oe_n |-> !fl_dq_oe);

    assert_done_pulse_R10: assert property (@(posedge clk) disable iff (rst)
        done |=> !done);

    assert_done_idle_R10: assert property (@(posedge clk) disable iff (rst)
        done |-> !busy);

    assert_fail_recover_R8: assert property (@(posedge clk) disable iff (rst)
        (done && !pass) |-> rcv_seen);

endmodule

bind flash_seq_top flash_seq_chk #(.AW(AW), .T_WP(T_WP)) u_chk (
    .clk(clk), .rst(rst), .req_start(req_start), .busy(busy), .done(done), .pass(pass),
    .fl_addr(fl_addr), .fl_dq_o(fl_dq_o), .fl_dq_oe(fl_dq_oe),
    .fl_ce_n(fl_ce_n), .fl_oe_n(fl_oe_n), .fl_we_n(fl_we_n)
);

// File: tb/test_flash_seq_top.sv
module test_flash_seq_top;
    localparam int AW = 18;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          req_start = 1'b0;
    logic [1:0]    req_kind = 2'd0;
    logic          req_poll = 1'b0;
    logic [AW-1:0] req_addr = '0;
    logic [7:0]    req_data = '0;
    logic          busy, done, pass;
    logic [AW-1:0] fl_addr;
    logic [7:0]    fl_dq_o, fl_dq_i;
    logic          fl_dq_oe, fl_ce_n, fl_oe_n, fl_we_n;

    int total = 0;
    int bad   = 0;
    int cyc   = 0;

    always #4 clk = ~clk;

    flash_seq_top #(.AW(AW), .T_AS(2), .T_WP(4), .T_WH(2), .T_OE(3), .MAX_POLL(40)) i_flash_seq_top (
        .clk(clk), .rst(rst), .req_start(req_start), .req_kind(req_kind), .req_poll(req_poll),
        .req_addr(req_addr), .req_data(req_data), .busy(busy), .done(done), .pass(pass),
        .fl_addr(fl_addr), .fl_dq_o(fl_dq_o), .fl_dq_oe(fl_dq_oe), .fl_dq_i(fl_dq_i),
        .fl_ce_n(fl_ce_n), .fl_oe_n(fl_oe_n), .fl_we_n(fl_we_n)
    );

    // behavioural flash responder
    int         rd_cnt = 0;
    int         rsp_busy = 0;
    int         rsp_err = 1000000;
    logic       rsp_exp7 = 1'b0;
    logic [7:0] rsp_final = '0;
    logic       we_p = 1'b1, oe_p = 1'b1;
    logic [AW-1:0] wr_addr = '0;
    int         n_writes = 0;
    int         n_reads = 0;

    always_comb begin
        if (rd_cnt < rsp_busy)
            fl_dq_i = {~rsp_exp7, rd_cnt[0], (rd_cnt >= rsp_err), 5'b0};
        else
            fl_dq_i = rsp_final;
    end

    // scoreboard of expected writes
    logic [AW-1:0] exp_a[$];
    logic [7:0]    exp_d[$];

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] expv, input string what);
        total++;
        if (act !== expv) begin
            bad++;
            $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, expv);
        end
    endtask

    always @(negedge clk) begin
        cyc++;
        if (cyc > 150000) begin
            bad++; total++;
            $display("FAIL watchdog: actual=hung expected=finish");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
        if (!fl_we_n && we_p) wr_addr = fl_addr;
        if (fl_we_n && !we_p) begin
            n_writes++;
            rd_cnt = 0;
            if (exp_a.size() == 0) begin
                chk("R10", 32'(fl_dq_o), 32'hFFFF, "unexpected write");
            end else begin
                chk("R1/R2/R8", 32'(wr_addr), 32'(exp_a.pop_front()), "write address");
                chk("R1/R2/R8", 32'(fl_dq_o), 32'(exp_d.pop_front()), "write data");
            end
        end
        if (fl_oe_n && !oe_p) begin
            rd_cnt++;
            n_reads++;
        end
        we_p = fl_we_n;
        oe_p = fl_oe_n;
    end

    task automatic push(input logic [AW-1:0] a, input logic [7:0] d);
        exp_a.push_back(a);
        exp_d.push_back(d);
    endtask

    task automatic run_op(input logic [1:0] k, input logic [AW-1:0] a, input logic [7:0] d,
                          input logic pm, input int bsy, input int err, input logic [7:0] fin,
                          input logic exp_pass, input string req, input logic poke);
        rsp_busy  = bsy;
        rsp_err   = err;
        rsp_exp7  = (k == 2'd0) ? d[7] : 1'b1;
        rsp_final = fin;
        push(18'h555, 8'hAA);
        push(18'h2AA, 8'h55);
        if (k == 2'd0) begin
            push(18'h555, 8'hA0);
            push(a, d);
        end else begin
            push(18'h555, 8'h80);
            push(18'h555, 8'hAA);
            push(18'h2AA, 8'h55);
            if (k == 2'd1) push(a, 8'h30); else push(18'h555, 8'h10);
        end
        if (!exp_pass) push('0, 8'hF0);
        @(negedge clk);
        req_kind = k; req_addr = a; req_data = d; req_poll = pm; req_start = 1'b1;
        @(negedge clk);
        req_start = 1'b0;
        chk("R10", 32'(busy), 32'd1, "busy after start");
        if (poke) begin
            repeat (5) @(negedge clk);
            req_kind = 2'd0; req_addr = 18'h00077; req_data = 8'h11; req_start = 1'b1;
            @(negedge clk);
            req_start = 1'b0;
        end
        while (!done) @(negedge clk);
        chk(req, 32'(pass), 32'(exp_pass), "verdict");
        chk("R10", 32'(busy), 32'd0, "busy with done");
        chk(req, 32'(exp_a.size()), 32'd0, "writes outstanding at done");
        @(negedge clk);
        chk("R10", 32'(done), 32'd0, "done one cycle");
    endtask

    initial begin
        repeat (3) @(negedge clk);
        chk("R11", 32'(busy), 32'd0, "reset busy");
        chk("R11", 32'(done), 32'd0, "reset done");
        chk("R11", 32'(pass), 32'd0, "reset pass");
        chk("R11", 32'({fl_ce_n, fl_oe_n, fl_we_n}), 32'd7, "reset strobes");
        rst = 1'b0;
        @(negedge clk);

        // R1 R5 program, bit-7 status, completes after 3 busy reads; start while busy ignored (R10)
        n_reads = 0;
        run_op(2'd0, 18'h01234, 8'h5A, 1'b0, 3, 1000000, 8'h5A, 1'b1, "R5", 1'b1);
        chk("R4", 32'(n_reads), 32'd4, "separate status reads");
        // R6 error bit seen, recheck passes
        n_reads = 0;
        run_op(2'd0, 18'h3FFFF, 8'hC3, 1'b0, 3, 2, 8'hC3, 1'b1, "R6", 1'b0);
        chk("R6", 32'(n_reads), 32'd4, "one recheck read");
        // R6 R8 error bit, recheck fails
        run_op(2'd0, 18'h00100, 8'h81, 1'b0, 1000000, 3, 8'h81, 1'b0, "R6", 1'b0);
        // R2 R5 sector erase
        run_op(2'd1, 18'h2A123, 8'h00, 1'b0, 5, 1000000, 8'hFF, 1'b1, "R2", 1'b0);
        // R2 R7 chip erase, toggle status
        run_op(2'd2, 18'h00000, 8'h00, 1'b1, 4, 1000000, 8'hFF, 1'b1, "R7", 1'b0);
        // R7 toggle with error bit, confirmation shows completion
        n_reads = 0;
        run_op(2'd1, 18'h10400, 8'h00, 1'b1, 3, 2, 8'hFF, 1'b1, "R7", 1'b0);
        chk("R7", 32'(n_reads), 32'd5, "two confirmation reads");
        // R7 R8 toggle keeps toggling
        run_op(2'd0, 18'h05555, 8'h3C, 1'b1, 1000000, 2, 8'h3C, 1'b0, "R7", 1'b0);
        // R9 read watchdog
        n_reads = 0;
        run_op(2'd0, 18'h0ABCD, 8'h00, 1'b0, 1000000, 1000000, 8'h00, 1'b0, "R9", 1'b0);
        chk("R9", 32'(n_reads), 32'd40, "reads before watchdog");

        // R10 kind 3 ignored
        n_writes = 0;
        @(negedge clk);
        req_kind = 2'd3; req_start = 1'b1;
        @(negedge clk);
        req_start = 1'b0;
        repeat (30) begin
            @(negedge clk);
            if (busy || !fl_ce_n) chk("R10", 32'({busy, fl_ce_n}), 32'd1, "kind 3 ignored");
        end
        chk("R10", 32'(n_writes), 32'd0, "kind 3 no writes");

        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule